// File: doc/BRIEF.md
# Scatter-Gather Segment Prefetcher

This block walks a list of scatter-gather descriptors that sit in host memory and hands one address/length pair at a time to a data-transfer engine. Each descriptor takes eight bytes. The low four bytes hold the segment's start address and the high four bytes hold its byte count, and both are little-endian. The block reads descriptors in bursts through a plain read request/response port and keeps them in a small local cache. It serves segments from that cache until the cache runs dry, and only then issues the next burst.

Software gives it a list pointer and a segment count, then pulses `start`. The transfer engine takes each offered segment and later reports one of two outcomes. Either the segment completed, or the bus changed phase early (an underrun) with some bytes still outstanding. The block flags the final segment of the list. When the list ends or an underrun stops it, the block pulses `done` and leaves the residual byte count and residual segment count on its outputs.

Top module: `sgp_engine`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req` and `seg_valid` are low and both residual outputs are zero.
- R2: A response beat carries one descriptor: `rsp_data[31:0]` is the segment address (bits 7:0 are its least significant byte) and `rsp_data[63:32]` is its length. The segment is offered with exactly those values, which hold steady while `seg_valid` waits for `seg_ready`.
- R3: When the cache holds no unread descriptor and segments remain, the block requests the next descriptor's address with a byte count of min(CACHE_SEGS, remaining segments) × 8.
- R4: While unread prefetched descriptors remain, the next segment is served from the cache with no memory request, so a list of N segments costs ceil(N / CACHE_SEGS) requests.
- R5: `seg_last` is high on the offered segment exactly when the remaining segment count is 1.
- R6: Each `xfer_done` decrements the remaining count. When it reaches zero, the run finishes with residual bytes 0 and residual segments 0.
- R7: The next-descriptor pointer advances by 8 for each accepted segment and wraps modulo 2^PTR_W.
- R8: `xfer_underrun` ends the run with no further segment or request. Residual bytes equal `xfer_left` and residual segments equal the remaining count, including the interrupted segment. An underrun wins over `xfer_done` in the same cycle.
- R9: `done` is a one-cycle pulse, and `busy` is high from the cycle after `start` through the `done` cycle. A `start` while busy is ignored.
- R10: A `start` with a segment count of zero finishes at once with both residuals zero and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin walking a list (taken only when idle) |
| list_ptr | input | PTR_W | Byte address of the first descriptor |
| seg_total | input | CNT_W | Number of descriptors in the list |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| rd_req | output | 1 | Descriptor read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | PTR_W | Byte address of the burst |
| rd_bytes | output | clog2(CACHE_SEGS+1)+3 | Byte count of the burst |
| rsp_valid | input | 1 | Response beat valid (one descriptor) |
| rsp_data | input | 64 | Descriptor, little-endian |
| seg_valid | output | 1 | Segment offered to the transfer engine |
| seg_ready | input | 1 | Transfer engine takes the segment |
| seg_addr | output | 32 | Segment start address |
| seg_len | output | 32 | Segment byte count |
| seg_last | output | 1 | Offered segment is the list's final one |
| xfer_done | input | 1 | Current segment fully moved |
| xfer_underrun | input | 1 | Phase change stopped the current segment |
| xfer_left | input | 24 | Bus-side bytes left at the underrun |
| resid_bytes | output | 24 | Residual byte count of the finished run |
| resid_segs | output | CNT_W | Residual segment count of the finished run |

## Verification
The bench builds the block with CACHE_SEGS = 3 and PTR_W = 16. A cache size that is not a power of two makes a seven-segment list split into bursts of 3, 3 and 1, and lets an underrun land in the middle of the second burst. The 16-bit pointer makes both cases reachable: a list at 0x00F0 crosses into the upper byte, and a list at 0xFFF8 wraps to zero between segments.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
  localparam int DESC_BYTES = 8;
  localparam int SEG_AW     = 32;
  localparam int SEG_LW     = 32;
  localparam int RESID_W    = 24;

  // packed so that bit 0 is byte 0 of the little-endian descriptor
  typedef struct packed {
    logic [SEG_LW-1:0] len;
    logic [SEG_AW-1:0] addr;
  } sg_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ISSUE,
    ST_RUN,
    ST_FINISH
  } eng_state_e;

  // how many descriptors one burst brings in
  function automatic int unsigned burst_segs(input int unsigned remain, input int unsigned cap);
    return (remain < cap) ? remain : cap;
  endfunction

  // little-endian byte lanes: bytes 0..3 address, bytes 4..7 length
  function automatic sg_desc_t unpack_desc(input logic [63:0] raw);
    sg_desc_t d;
    d.addr = {raw[31:24], raw[23:16], raw[15:8], raw[7:0]};
    d.len  = {raw[63:56], raw[55:48], raw[47:40], raw[39:32]};
    return d;
  endfunction
endpackage

// File: rtl/sgp_fetch.sv
module sgp_fetch
  import sgp_pkg::*;
#(
  parameter int PTR_W      = 16,
  parameter int CACHE_SEGS = 4,
  localparam int OCC_W     = $clog2(CACHE_SEGS + 1),
  localparam int IDX_W     = (CACHE_SEGS > 1) ? $clog2(CACHE_SEGS) : 1,
  localparam int BYTES_W   = OCC_W + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [PTR_W-1:0]   go_addr,
  input  logic [OCC_W-1:0]   go_segs,
  output logic               rd_req,
  input  logic               rd_ready,
  output logic [PTR_W-1:0]   rd_addr,
  output logic [BYTES_W-1:0] rd_bytes,
  input  logic               rsp_valid,
  input  logic [63:0]        rsp_data,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output sg_desc_t           wr_data,
  output logic               fill_done
);
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_RSP} fetch_state_e;

  fetch_state_e       f_state;
  logic [PTR_W-1:0]   addr_q;
  logic [OCC_W-1:0]   want_q;
  logic [OCC_W-1:0]   beat_q;
  logic               last_beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_state <= F_IDLE;
      addr_q  <= '0;
      want_q  <= '0;
      beat_q  <= '0;
    end else begin
      case (f_state)
        F_IDLE: if (go) begin
          addr_q  <= go_addr;
          want_q  <= go_segs;
          beat_q  <= '0;
          f_state <= F_REQ;
        end
        F_REQ: if (rd_ready) f_state <= F_RSP;
        F_RSP: if (rsp_valid) begin
          beat_q <= beat_q + OCC_W'(1);
          if (last_beat) f_state <= F_IDLE;
        end
        default: f_state <= F_IDLE;
      endcase
    end
  end

  assign last_beat = (beat_q == want_q - OCC_W'(1));
  assign rd_req    = (f_state == F_REQ);
  assign rd_addr   = addr_q;
  assign rd_bytes  = {want_q, 3'b000};
  assign wr_en     = (f_state == F_RSP) && rsp_valid;
  assign wr_idx    = beat_q[IDX_W-1:0];
  assign wr_data   = unpack_desc(rsp_data);
  assign fill_done = wr_en && last_beat;

  AST_BEAT_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (beat_q < want_q)); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr) && $stable(rd_bytes))); // R3
  AST_BURST_SIZE: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (want_q != '0 && want_q <= OCC_W'(CACHE_SEGS))); // R3
endmodule

// File: rtl/sgp_cache.sv
module sgp_cache
  import sgp_pkg::*;
#(
  parameter int CACHE_SEGS = 4,
  localparam int OCC_W     = $clog2(CACHE_SEGS + 1),
  localparam int IDX_W     = (CACHE_SEGS > 1) ? $clog2(CACHE_SEGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  sg_desc_t         wr_data,
  input  logic             fill_done,
  input  logic [OCC_W-1:0] fill_n,
  input  logic             pop,
  output sg_desc_t         head,
  output logic             empty
);
  sg_desc_t [CACHE_SEGS-1:0] slot_view;
  logic [OCC_W-1:0]          avail_q;
  logic [IDX_W-1:0]          rd_ptr;

  for (genvar s = 0; s < CACHE_SEGS; s++) begin : g_slot
    sg_desc_t q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(s))) q <= wr_data;
    end
    assign slot_view[s] = q;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      avail_q <= '0;
      rd_ptr  <= '0;
    end else if (fill_done) begin
      avail_q <= fill_n;
      rd_ptr  <= '0;
    end else if (pop && avail_q != '0) begin
      avail_q <= avail_q - OCC_W'(1);
      rd_ptr  <= (avail_q == OCC_W'(1)) ? '0 : rd_ptr + IDX_W'(1);
    end
  end

  assign head  = slot_view[rd_ptr];
  assign empty = (avail_q == '0);

  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R4
  AST_FILL_ONLY_DRAINED: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> empty); // R4
endmodule

// File: rtl/sgp_engine.sv
module sgp_engine
  import sgp_pkg::*;
#(
  parameter int PTR_W      = 16,
  parameter int CNT_W      = 8,
  parameter int CACHE_SEGS = 4,
  localparam int OCC_W     = $clog2(CACHE_SEGS + 1),
  localparam int IDX_W     = (CACHE_SEGS > 1) ? $clog2(CACHE_SEGS) : 1,
  localparam int BYTES_W   = OCC_W + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [PTR_W-1:0]   list_ptr,
  input  logic [CNT_W-1:0]   seg_total,
  output logic               busy,
  output logic               done,
  output logic               rd_req,
  input  logic               rd_ready,
  output logic [PTR_W-1:0]   rd_addr,
  output logic [BYTES_W-1:0] rd_bytes,
  input  logic               rsp_valid,
  input  logic [63:0]        rsp_data,
  output logic               seg_valid,
  input  logic               seg_ready,
  output logic [SEG_AW-1:0]  seg_addr,
  output logic [SEG_LW-1:0]  seg_len,
  output logic               seg_last,
  input  logic               xfer_done,
  input  logic               xfer_underrun,
  input  logic [RESID_W-1:0] xfer_left,
  output logic [RESID_W-1:0] resid_bytes,
  output logic [CNT_W-1:0]   resid_segs
);
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p + PTR_W'(DESC_BYTES);
  endfunction

  eng_state_e         state;
  logic [CNT_W-1:0]   remain;
  logic [PTR_W-1:0]   next_ptr;

  // named events for the assertions
  logic ev_start, ev_seg_fire, ev_under, ev_seg_ok, ev_final;
  logic fetch_go, cache_empty, fill_done, wr_en;
  logic [CNT_W-1:0]   fetch_remain;
  logic [PTR_W-1:0]   fetch_addr;
  logic [OCC_W-1:0]   fetch_segs;
  logic [IDX_W-1:0]   wr_idx;
  sg_desc_t           wr_data, head;

  assign ev_start    = (state == ST_IDLE) && start;
  assign ev_seg_fire = (state == ST_ISSUE) && seg_ready;
  assign ev_under    = (state == ST_RUN) && xfer_underrun;
  assign ev_seg_ok   = (state == ST_RUN) && xfer_done && !xfer_underrun;
  assign ev_final    = ev_seg_ok && (remain == CNT_W'(1));

  assign fetch_go     = (ev_start && seg_total != '0) || (ev_seg_ok && !ev_final && cache_empty);
  assign fetch_remain = ev_start ? seg_total : remain - CNT_W'(1);
  assign fetch_addr   = ev_start ? list_ptr : next_ptr;
  assign fetch_segs   = OCC_W'(burst_segs(32'(fetch_remain), CACHE_SEGS));

  sgp_fetch #(.PTR_W(PTR_W), .CACHE_SEGS(CACHE_SEGS)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .go        (fetch_go),
    .go_addr   (fetch_addr),
    .go_segs   (fetch_segs),
    .rd_req    (rd_req),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .rd_bytes  (rd_bytes),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .fill_done (fill_done)
  );

  sgp_cache #(.CACHE_SEGS(CACHE_SEGS)) u_cache (
    .clk       (clk),
    .rst       (rst),
    .flush     (ev_start),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .fill_done (fill_done),
    .fill_n    (fetch_segs_q),
    .pop       (ev_seg_fire),
    .head      (head),
    .empty     (cache_empty)
  );

  // burst size of the fill in flight, for the cache occupancy
  logic [OCC_W-1:0] fetch_segs_q;
  always_ff @(posedge clk) begin
    if (rst)           fetch_segs_q <= '0;
    else if (fetch_go) fetch_segs_q <= fetch_segs;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      remain      <= '0;
      next_ptr    <= '0;
      resid_bytes <= '0;
      resid_segs  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          remain   <= seg_total;
          next_ptr <= list_ptr;
          if (seg_total == '0) begin
            resid_bytes <= '0;
            resid_segs  <= '0;
            state       <= ST_FINISH;
          end else begin
            state <= ST_FETCH;
          end
        end
        ST_FETCH: if (fill_done) state <= ST_ISSUE;
        ST_ISSUE: if (seg_ready) begin
          next_ptr <= ptr_step(next_ptr);
          state    <= ST_RUN;
        end
        ST_RUN: begin
          if (xfer_underrun) begin
            resid_bytes <= xfer_left;
            resid_segs  <= remain;
            state       <= ST_FINISH;
          end else if (xfer_done) begin
            remain <= remain - CNT_W'(1);
            if (remain == CNT_W'(1)) begin
              resid_bytes <= '0;
              resid_segs  <= '0;
              state       <= ST_FINISH;
            end else if (cache_empty) begin
              state <= ST_FETCH;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FINISH);
  assign seg_valid = (state == ST_ISSUE);
  assign seg_addr  = head.addr;
  assign seg_len   = head.len;
  assign seg_last  = seg_valid && (remain == CNT_W'(1));

  AST_SEG_HELD: assert property (@(posedge clk) disable iff (rst)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len))); // R2
  AST_SEG_HAS_WORK: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> (remain != '0)); // R5
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    ev_seg_ok |=> (remain == $past(remain) - CNT_W'(1))); // R6
  AST_FINAL_RESID: assert property (@(posedge clk) disable iff (rst)
    ev_final |=> (done && resid_bytes == '0 && resid_segs == '0)); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    ev_seg_fire |=> (next_ptr == $past(next_ptr) + PTR_W'(8))); // R7
  AST_UNDER_ENDS: assert property (@(posedge clk) disable iff (rst)
    ev_under |=> (done && !seg_valid && !rd_req)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_ZERO_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (ev_start && seg_total == '0) |=> (done && !rd_req)); // R10
endmodule

// File: tb/sgp_engine_test.sv
`timescale 1ns/1ps
module sgp_engine_test;
  localparam int PTR_W   = 16;
  localparam int CNT_W   = 8;
  localparam int C       = 3;
  localparam int BYTES_W = $clog2(C + 1) + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic               start = 0, rd_ready = 1, rsp_valid = 0, seg_ready = 1;
  logic               xfer_done = 0, xfer_underrun = 0;
  logic [PTR_W-1:0]   list_ptr = '0;
  logic [CNT_W-1:0]   seg_total = '0;
  logic [63:0]        rsp_data = '0;
  logic [23:0]        xfer_left = '0;
  logic               busy, done, rd_req, seg_valid, seg_last;
  logic [PTR_W-1:0]   rd_addr;
  logic [BYTES_W-1:0] rd_bytes;
  logic [31:0]        seg_addr, seg_len;
  logic [23:0]        resid_bytes;
  logic [CNT_W-1:0]   resid_segs;

  sgp_engine #(.PTR_W(PTR_W), .CNT_W(CNT_W), .CACHE_SEGS(C)) uut (
    .clk(clk), .rst(rst), .start(start), .list_ptr(list_ptr), .seg_total(seg_total),
    .busy(busy), .done(done), .rd_req(rd_req), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_bytes(rd_bytes), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
    .seg_last(seg_last), .xfer_done(xfer_done), .xfer_underrun(xfer_underrun),
    .xfer_left(xfer_left), .resid_bytes(resid_bytes), .resid_segs(resid_segs));

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // host memory model: descriptor contents derived from its byte address
  function automatic logic [31:0] mem_a(input logic [PTR_W-1:0] p);
    return 32'h4000_0000 | {8'h00, p, 8'h5A};
  endfunction
  function automatic logic [31:0] mem_l(input logic [PTR_W-1:0] p);
    return {16'h0001, p ^ 16'h0F0F};
  endfunction

  // one run: n segments from p0; underrun on segment u (-1: none)
  task automatic run_job(input int n, input logic [PTR_W-1:0] p0, input int u,
                         input logic [23:0] left, input bit poke, input bit both);
    int k = 0, reqs = 0, pend = 0, xw = 0, cur = 0, cyc = 0;
    bit fin = 0;
    logic [PTR_W-1:0] rptr = '0;
    int issued = (u >= 0) ? u + 1 : n;
    @(negedge clk);
    list_ptr = p0; seg_total = CNT_W'(n); start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    while (!fin && cyc < 2000) begin
      cyc++;
      start = 0; rsp_valid = 0; xfer_done = 0; xfer_underrun = 0;
      if (done) begin
        fin = 1;
        chk(resid_bytes == ((u >= 0) ? left : 24'd0), (u >= 0) ? "R8" : "R6",
            "resid bytes", resid_bytes, (u >= 0) ? left : 0);
        chk(resid_segs == CNT_W'((u >= 0) ? n - u : 0), (u >= 0) ? "R8" : "R6",
            "resid segs", resid_segs, (u >= 0) ? n - u : 0);
      end else begin
        if (pend > 0) begin
          rsp_valid = 1; rsp_data = {mem_l(rptr), mem_a(rptr)};
          rptr = rptr + PTR_W'(8); pend--;
        end
        if (rd_req) begin
          int bs = (n - k < C) ? n - k : C;
          reqs++;
          chk(k % C == 0, "R4", "request with cache unread", k, 0);
          chk(rd_addr == p0 + PTR_W'(8 * k), "R3", "request addr", rd_addr, p0 + PTR_W'(8 * k));
          chk(rd_bytes == BYTES_W'(bs * 8), "R3", "request bytes", rd_bytes, bs * 8);
          pend = bs; rptr = rd_addr;
        end
        if (xw == 1) begin
          xw = 0;
          if (cur == u) begin xfer_underrun = 1; xfer_left = left; xfer_done = both; end
          else xfer_done = 1;
        end
        if (seg_valid) begin
          logic [PTR_W-1:0] da = p0 + PTR_W'(8 * k);
          chk(seg_addr == mem_a(da), "R2", "seg addr", seg_addr, mem_a(da));
          chk(seg_len == mem_l(da), "R2", "seg len", seg_len, mem_l(da));
          chk(seg_last == (k == n - 1), "R5", "seg last", seg_last, k == n - 1);
          if (poke && k == 0) begin start = 1; list_ptr = 16'h7000; seg_total = 8'd9; end
          cur = k; k++; xw = 1;
        end
      end
      if (!fin) @(negedge clk);
    end
    chk(fin, "R9", "run finished", fin, 1);
    chk(k == issued, "R8", "segments issued", k, issued);
    chk(reqs == (issued + C - 1) / C, "R4", "request count", reqs, (issued + C - 1) / C);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9", "done one cycle", {done, busy}, 0);
  endtask

  // {count, pointer, underrun index (FF none), bytes left}
  localparam logic [55:0] VEC [7] = '{
    {8'd1, 16'h0100, 8'hFF, 24'h000000},
    {8'd3, 16'h0200, 8'hFF, 24'h000000},
    {8'd7, 16'h0300, 8'hFF, 24'h000000},
    {8'd5, 16'h00F0, 8'hFF, 24'h000000},
    {8'd6, 16'h0400, 8'd4,  24'h001234},
    {8'd4, 16'h0500, 8'd0,  24'hABCDEF},
    {8'd2, 16'hFFF8, 8'hFF, 24'h000000}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_req && !seg_valid, "R1", "control outputs after reset",
        {busy, done, rd_req, seg_valid}, 0);
    chk(resid_bytes == 0 && resid_segs == 0, "R1", "residuals after reset",
        {resid_bytes, resid_segs}, 0);
    rst = 0;
    for (int i = 0; i < 7; i++) begin
      int n = int'(VEC[i][55:48]);
      int u = (VEC[i][31:24] == 8'hFF) ? -1 : int'(VEC[i][31:24]);
      run_job(n, VEC[i][47:32], u, VEC[i][23:0], 1'b0, 1'b0); // R3 R5 R6 R7
    end
    // R10: empty list
    run_job(0, 16'h0800, -1, 24'h0, 1'b0, 1'b0);
    // R9: start while busy has no effect on the run
    run_job(4, 16'h0900, -1, 24'h0, 1'b1, 1'b0);
    // R8: underrun and done together, underrun wins
    run_job(5, 16'h0A00, 3, 24'h00_0F0F, 1'b0, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule